// File: doc/BRIEF.md
# Burst-Mode Slave Line Turnaround Controller

This block sits at the terminal end of a two-wire digital subscriber link. On that link the far end owns loop timing, and the two ends take turns sending time-compressed bursts. The block receives one ternary line symbol per symbol strobe. While the line is idle it waits for the unscrambled burst start mark. It then collects a fixed payload of 36 bits. It turns each alternate-mark-inverted symbol back into a binary bit and removes the line scrambling with a self-synchronising descrambler. It presents the two frames of B1, B2 and D data in parallel, together with a single-cycle strobe.

After the last payload bit the block blanks its receiver and holds the line quiet for a guard interval of six symbol periods. It then sends its own reply burst in the same format: a start mark, followed by 36 scrambled, alternate-mark-inverted payload bits taken from its parallel transmit input. The receive window reopens only after the last reply symbol has gone out. All state advances only on cycles where the symbol strobe is high, so the block can run from a system clock that is faster than the line rate.

Top module: `burst_slave_turnaround`

## Requirements
- R1: After reset, rx_en is 1, and tx_sym, bpv and frame_valid are 0. The last received mark and the last transmitted mark are both taken to be negative. The descrambler and scrambler shift registers start at all zeros.
- R2: Line symbols use a 2-bit code in which bit 0 means a mark is present and bit 1 means the mark is negative. So 2'b01 is +1, 2'b11 is -1, and 2'b00 and 2'b10 are both zero. While idle, a mark whose polarity is opposite to the last received mark starts a burst. Zero symbols leave the block idle.
- R3: While idle, a mark with the same polarity as the last received mark is a bipolar violation. It raises bpv for exactly one cycle and is otherwise ignored: it changes neither the state nor the stored polarity.
- R4: The 36 symbols that follow the start mark are payload. A nonzero symbol decodes to 1 and a zero symbol decodes to 0. Each decoded bit is descrambled as out = in ^ h[4] ^ h[8], where h holds the previously received scrambled payload bits and h[0] is the most recent. The start mark does not pass through the descrambler.
- R5: On the clock edge that accepts the 36th payload symbol, frame_valid pulses for one cycle and frame_data is updated. In frame_data, bit 0 is the first payload bit received. The field layout is: [7:0] B1 of frame 1, [15:8] B2 of frame 1, [17:16] D of frame 1, [25:18] B1 of frame 2, [33:26] B2 of frame 2, [35:34] D of frame 2.
- R6: On that same edge rx_en falls. It stays low through the guard interval and the reply. Line symbols that arrive during this time have no effect: no bpv, no polarity update, no descrambler update.
- R7: Exactly 6 zero symbol slots separate the last received payload symbol from the reply start mark.
- R8: The reply begins with a start mark whose polarity is opposite to the last transmitted mark. It is followed by 36 symbols carrying tx_payload, sampled on the frame_valid edge, bit 0 first. Each bit is scrambled as s = d ^ t[4] ^ t[8] and sent with marks of alternating polarity. tx_sym is never 2'b10.
- R9: On the symbol edge after the last reply symbol, tx_sym returns to zero and rx_en rises again. tx_sym is zero whenever rx_en is 1.
- R10: On cycles where sym_en is 0, rx_sym is ignored, and none of the outputs other than the one-cycle pulses change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_en | input | 1 | Symbol strobe, one cycle per line symbol |
| rx_sym | input | 2 | Received ternary symbol (bit 0 mark, bit 1 negative) |
| tx_payload | input | 36 | Reply payload, sampled on the frame_valid edge |
| rx_en | output | 1 | Receive window open |
| bpv | output | 1 | One-cycle bipolar violation flag while idle |
| frame_valid | output | 1 | One-cycle strobe when frame_data is new |
| frame_data | output | 36 | Descrambled payload of the last burst |
| tx_sym | output | 2 | Transmitted ternary symbol |

## Verification
The bench sends a same-polarity mark while the block is idle. A design that took it as a start would shift every later frame and fail the scoreboard comparison. During the guard interval and the reply, the bench drives marks that would be valid starts. A receiver that did not really blank itself would either pick up a wrong polarity, so that the next genuine start is flagged as a violation, or corrupt its descrambler history. Both show up as mismatched frames. Each reply is descrambled independently and its guard length counted symbol by symbol, so an off-by-one in the guard or bit counters moves the start mark or drops a bit. A mark presented with the strobe low must not start a burst.

// File: rtl/burst_slave_turnaround.sv
module burst_slave_turnaround #(
  parameter int PAYLOAD_BITS = 36,
  parameter int GUARD_SYMS   = 6,
  parameter int SCR_LEN      = 9,
  parameter int SCR_TAP      = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sym_en,
  input  logic [1:0]              rx_sym,
  input  logic [PAYLOAD_BITS-1:0] tx_payload,
  output logic                    rx_en,
  output logic                    bpv,
  output logic                    frame_valid,
  output logic [PAYLOAD_BITS-1:0] frame_data,
  output logic [1:0]              tx_sym
);

  localparam int CW = $clog2(PAYLOAD_BITS + 1);
  localparam int GW = $clog2(GUARD_SYMS + 1);
  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [1:0] SYM_POS  = 2'b01;
  localparam logic [1:0] SYM_NEG  = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_RX, S_GUARD, S_TX} state_t;

  state_t                  state;
  logic [CW-1:0]           bit_cnt;
  logic [GW-1:0]           guard_cnt;
  logic [SCR_LEN-1:0]      dsr;
  logic [SCR_LEN-1:0]      ssr;
  logic                    rx_last_neg;
  logic                    tx_last_neg;
  logic [PAYLOAD_BITS-1:0] rx_shift;
  logic [PAYLOAD_BITS-1:0] tx_buf;

  logic rx_mark, rx_neg, desc_bit, scr_bit;

  assign rx_mark  = rx_sym[0];
  assign rx_neg   = rx_sym[1];
  assign desc_bit = rx_mark ^ dsr[SCR_TAP-1] ^ dsr[SCR_LEN-1];
  assign scr_bit  = tx_buf[0] ^ ssr[SCR_TAP-1] ^ ssr[SCR_LEN-1];
  assign rx_en    = (state == S_IDLE) || (state == S_RX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      bit_cnt     <= '0;
      guard_cnt   <= '0;
      dsr         <= '0;
      ssr         <= '0;
      rx_last_neg <= 1'b1;
      tx_last_neg <= 1'b1;
      rx_shift    <= '0;
      tx_buf      <= '0;
      frame_data  <= '0;
      frame_valid <= 1'b0;
      bpv         <= 1'b0;
      tx_sym      <= SYM_ZERO;
    end else begin
      frame_valid <= 1'b0;
      bpv         <= 1'b0;
      if (sym_en) begin
        case (state)
          S_IDLE: begin
            if (rx_mark) begin
              if (rx_neg != rx_last_neg) begin
                rx_last_neg <= rx_neg;
                bit_cnt     <= '0;
                state       <= S_RX;
              end else begin
                bpv <= 1'b1;
              end
            end
          end
          S_RX: begin
            dsr      <= {dsr[SCR_LEN-2:0], rx_mark};
            rx_shift <= {desc_bit, rx_shift[PAYLOAD_BITS-1:1]};
            if (rx_mark) rx_last_neg <= rx_neg;
            if (bit_cnt == CW'(PAYLOAD_BITS - 1)) begin
              frame_data  <= {desc_bit, rx_shift[PAYLOAD_BITS-1:1]};
              frame_valid <= 1'b1;
              tx_buf      <= tx_payload;
              guard_cnt   <= '0;
              state       <= S_GUARD;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          S_GUARD: begin
            if (guard_cnt == GW'(GUARD_SYMS - 1)) begin
              tx_sym      <= tx_last_neg ? SYM_POS : SYM_NEG;
              tx_last_neg <= ~tx_last_neg;
              bit_cnt     <= '0;
              state       <= S_TX;
            end else begin
              guard_cnt <= guard_cnt + 1'b1;
            end
          end
          S_TX: begin
            if (bit_cnt == CW'(PAYLOAD_BITS)) begin
              tx_sym <= SYM_ZERO;
              state  <= S_IDLE;
            end else begin
              ssr     <= {ssr[SCR_LEN-2:0], scr_bit};
              tx_buf  <= tx_buf >> 1;
              bit_cnt <= bit_cnt + 1'b1;
              if (scr_bit) begin
                tx_sym      <= tx_last_neg ? SYM_POS : SYM_NEG;
                tx_last_neg <= ~tx_last_neg;
              end else begin
                tx_sym <= SYM_ZERO;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/burst_slave_turnaround_chk.sv
module burst_slave_turnaround_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_en,
  input logic       rx_en,
  input logic       bpv,
  input logic       frame_valid,
  input logic [1:0] tx_sym
);

  a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  a_r3_bpv_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bpv |=> !bpv);

  a_r6_rx_off_at_valid: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> !rx_en);

  a_r6_bpv_only_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    bpv |-> rx_en);

  a_r9_quiet_while_open: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |-> (tx_sym == 2'b00));

  a_r8_tx_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sym != 2'b10);

  a_r10_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_en |=> ($stable(tx_sym) && $stable(rx_en) && !frame_valid && !bpv));

endmodule

bind burst_slave_turnaround burst_slave_turnaround_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .rx_en(rx_en),
  .bpv(bpv), .frame_valid(frame_valid), .tx_sym(tx_sym)
);

// File: tb/burst_slave_turnaround_tb.sv
module burst_slave_turnaround_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sym_en = 1'b0;
  logic [1:0]    rx_sym = 2'b00;
  logic [NB-1:0] tx_payload = '0;
  logic          rx_en, bpv, frame_valid;
  logic [NB-1:0] frame_data;
  logic [1:0]    tx_sym;

  int checks = 0;
  int errors = 0;
  logic [NB-1:0] exp_q[$];
  logic       m_rx_neg = 1'b1;
  logic       m_tx_neg = 1'b1;
  logic [8:0] m_scr = '0;
  logic [8:0] m_dsr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_slave_turnaround u_dut (
    .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .rx_sym(rx_sym),
    .tx_payload(tx_payload), .rx_en(rx_en), .bpv(bpv),
    .frame_valid(frame_valid), .frame_data(frame_data), .tx_sym(tx_sym)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [1:0] s);
    @(negedge clk);
    rx_sym = s;
    sym_en = 1'b1;
    @(negedge clk);
    sym_en = 1'b0;
    rx_sym = 2'b00;
  endtask

  always @(negedge clk) begin
    if (rst_n && frame_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected frame", 64'(frame_data), 64'h0);
      end else begin
        logic [NB-1:0] e;
        e = exp_q.pop_front();
        check(frame_data == e, "R4 R5 frame data", 64'(frame_data), 64'(e));
      end
    end
  end

  task automatic send_burst(input logic [NB-1:0] data, input logic [NB-1:0] reply);
    logic [1:0]    s;
    logic [1:0]    bait;
    logic [NB-1:0] got;
    logic          line, d;
    int            bad_pol;
    int            rx_open;
    tx_payload = reply;
    exp_q.push_back(data);
    s = m_rx_neg ? 2'b01 : 2'b11;
    m_rx_neg = ~m_rx_neg;
    tick(s);
    rx_open = 0;
    for (int i = 0; i < NB; i++) begin
      line = data[i] ^ m_scr[4] ^ m_scr[8];
      m_scr = {m_scr[7:0], line};
      if (line) begin
        s = m_rx_neg ? 2'b01 : 2'b11;
        m_rx_neg = ~m_rx_neg;
      end else begin
        s = (i % 3 == 0) ? 2'b10 : 2'b00;
      end
      if (i > 0 && rx_en) rx_open++;
      tick(s);
    end
    check(rx_open == NB - 1, "R6 rx_en open during payload", 64'(rx_open), 64'(NB - 1));
    check(rx_en == 1'b0, "R6 rx_en low after last payload", 64'(rx_en), 64'h0);
    check(tx_sym == 2'b00, "R7 guard slot 1", 64'(tx_sym), 64'h0);
    bait = m_rx_neg ? 2'b01 : 2'b11;
    for (int g = 0; g < 5; g++) begin
      tick(bait);
      check(tx_sym == 2'b00 && !bpv, "R7 guard quiet", 64'({bpv, tx_sym}), 64'h0);
    end
    tick(bait);
    s = m_tx_neg ? 2'b01 : 2'b11;
    m_tx_neg = ~m_tx_neg;
    check(tx_sym == s, "R7 R8 reply start mark", 64'(tx_sym), 64'(s));
    bad_pol = 0;
    got = '0;
    for (int i = 0; i < NB; i++) begin
      tick(bait);
      if (rx_en || bpv) bad_pol++;
      line = tx_sym[0];
      if (line) begin
        if (tx_sym != (m_tx_neg ? 2'b01 : 2'b11)) bad_pol++;
        m_tx_neg = ~m_tx_neg;
      end else if (tx_sym != 2'b00) begin
        bad_pol++;
      end
      d = line ^ m_dsr[4] ^ m_dsr[8];
      m_dsr = {m_dsr[7:0], line};
      got[i] = d;
    end
    check(bad_pol == 0, "R8 R6 reply AMI and blanking", 64'(bad_pol), 64'h0);
    check(got == reply, "R8 reply payload", 64'(got), 64'(reply));
    tick(2'b00);
    check(rx_en == 1'b1 && tx_sym == 2'b00, "R9 receive reopens", 64'({rx_en, tx_sym}), 64'h4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", 64'h0, 64'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rx_en == 1'b1 && tx_sym == 2'b00 && !bpv && !frame_valid,
          "R1 reset state", 64'({rx_en, bpv, frame_valid, tx_sym}), 64'h10);
    rst_n = 1'b1;

    tick(2'b00);
    tick(2'b10);
    check(rx_en == 1'b1 && !bpv, "R2 zero symbols keep idle", 64'({rx_en, bpv}), 64'h2);

    tick(2'b11);
    check(bpv == 1'b1, "R3 same-polarity mark flagged", 64'(bpv), 64'h1);
    tick(2'b00);
    check(bpv == 1'b0 && rx_en == 1'b1, "R3 flag clears, still idle", 64'({rx_en, bpv}), 64'h2);

    @(negedge clk);
    rx_sym = 2'b01;
    @(negedge clk);
    rx_sym = 2'b00;
    check(rx_en == 1'b1 && !bpv, "R10 mark without strobe ignored", 64'({rx_en, bpv}), 64'h2);

    send_burst(36'h0_0000_0000, 36'hF_FFFF_FFFF);
    send_burst(36'hF_FFFF_FFFF, 36'h0_0000_0000);
    send_burst(36'hA_5C39_6E1B, 36'h1_2345_6789);
    tick(2'b00);
    send_burst(36'h3_C0FF_EE42, 36'hB_EEF0_0D17);

    s_bpv_again();
    send_burst(36'h5_5555_5555, 36'hA_AAAA_AAAA);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 every frame delivered", 64'(exp_q.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic s_bpv_again();
    logic [1:0] same;
    same = m_rx_neg ? 2'b11 : 2'b01;
    tick(same);
    check(bpv == 1'b1 && rx_en == 1'b1, "R3 violation after burst", 64'({rx_en, bpv}), 64'h3);
  endtask

endmodule